// File: doc/BRIEF.md
# Timing Trigger Validation Handler

This block sits in a detector endpoint and decides whether each trigger is genuine. Two things make up one trigger. The first is an asynchronous timing pulse on a dedicated wire. The second is a trigger message that arrives later over the network. The network side delivers that message to this block as a one-cycle strobe. The handler brings the timing wire into the clock domain and applies an optional polarity inversion. It measures the length of each pulse and then pairs the pulses with the messages.

The block reports the result in two forms. One-cycle strobes mark each accepted trigger and each rejected one. Level flags record the problems seen along the way:
- a pulse too short to count,
- extra timing pulses,
- a message that came too late.

The flags are also gathered into a four-bit status word, which the trigger channel returns. After every accepted or rejected trigger the handler stays busy until the user logic asserts release. The release also clears the problem flags.

Top module: `timing_trigger_handler`

## Requirements
- R1: After a synchronous active-low reset, every output is low: both strobes, busy, all flags and the whole status word.
- R2: In idle, a timing pulse that stays active for at least MIN_PULSE_CYC cycles produces exactly one one-cycle `valid_o` strobe. The strobe appears MIN_PULSE_CYC+2 rising edges after the first edge that samples the input active. A pulse that stays active much longer still yields only one strobe.
- R3: A pulse active for fewer than MIN_PULSE_CYC cycles produces neither strobe. Two edges after the pulse ends, `spike_o` and status bit 3 go high.
- R4: A qualified pulse that arrives while the handler is busy produces no strobe. Instead it raises `multi_o` and status bit 1, which stay high until a release is accepted.
- R5: A message strobe that arrives in idle with no qualified pulse gives a one-cycle `invalid_o` on the next edge. It also sets status bit 0.
- R6: A release in idle or while waiting for the message is ignored. After either strobe, the handler takes no new trigger until a release is accepted. A message that arrives while waiting for release is ignored.
- R7: If no message arrives within MSG_TIMEOUT_CYC cycles of the `valid_o` strobe, `timeout_o` and status bit 2 go high. A message that arrives later still moves the handler to wait for release.
- R8: When `trg_invert_i` is high, the timing wire is active low. Pulse qualification and spike detection then work as in R2 and R3, on the inverted level.
- R9: An accepted release clears `multi_o`, `timeout_o`, `spike_o` and the status word. A release takes priority over a qualified pulse in the same cycle, and that pulse is dropped.
- R10: `busy_o` goes high with either strobe and falls on the edge that accepts a release.
- R11: If a pulse qualifies in the same cycle that the message strobe arrives, the result is `valid_o` and a direct wait for release, with no timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trg_raw_i | input | 1 | Asynchronous timing trigger wire |
| trg_invert_i | input | 1 | High: timing wire is active low |
| msg_strobe_i | input | 1 | One-cycle strobe when a trigger message is received |
| release_i | input | 1 | User release of the current trigger |
| valid_o | output | 1 | One-cycle strobe: trigger accepted |
| invalid_o | output | 1 | One-cycle strobe: message without a timing pulse |
| busy_o | output | 1 | A trigger is pending or awaits release |
| multi_o | output | 1 | Extra timing pulse seen during a trigger |
| spike_o | output | 1 | Short pulse seen |
| timeout_o | output | 1 | Message later than the timeout window |
| status_o | output | 4 | bit0 missing pulse, bit1 multiple, bit2 late, bit3 spike |

## Verification
The assertions check the following on every cycle:
- both strobes last one cycle and never fire together;
- every strobe coincides with busy;
- busy and the timeout flag only drop on a release;
- the multiple flag never appears outside a busy period;
- an accepted release clears the flags.

Only the bench's scenarios can show the exact latency from the wire to the strobe, and the spike threshold boundary. The same holds for the timeout window length, the effect of the inverted polarity, and the priority of a release over a pulse that qualifies in the same cycle. The bench compares these against a behavioural model on every clock.

// File: rtl/th_pkg.sv
// Shared types for the timing trigger handler.
// Assumes: status word positions are decoded by the trigger channel logic.
package th_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_MSG = 2'd1,
        ST_TIMEOUT  = 2'd2,
        ST_WAIT_REL = 2'd3
    } th_state_e;

    localparam int STAT_W      = 4;
    localparam int STAT_MISSING = 0;
    localparam int STAT_MULTI   = 1;
    localparam int STAT_LATE    = 2;
    localparam int STAT_SPIKE   = 3;
endpackage

// File: rtl/th_sync.sv
// Polarity select and synchroniser for the asynchronous timing wire.
// Inversion is applied before the first flop so that reset (all zero)
// always reads as "inactive" whatever the polarity setting.
// Assumes: trg_invert_i is quasi-static.
module th_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic invert_i,
    output logic lvl_o
);
    logic [STAGES-1:0] pipe;

    // Shift the polarity-corrected wire through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-2:0], raw_i ^ invert_i};
        end
    end

    assign lvl_o = pipe[STAGES-1];
endmodule

// File: rtl/th_width.sv
// Measures how long the synchronised timing level stays active.
// qual_o pulses once, in the cycle the active run reaches MIN_CYC cycles;
// spike_o pulses in the first inactive cycle after a run shorter than MIN_CYC.
// Assumes: MIN_CYC >= 2.
module th_width #(
    parameter int MIN_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic qual_o,
    output logic spike_o
);
    localparam int CW = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);
    localparam logic [CW-1:0] SAT  = CW'(MIN_CYC);

    logic [CW-1:0] run_cnt;

    // Count active cycles, saturating at the threshold, clear when inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!lvl_i) begin
            run_cnt <= '0;
        end else if (run_cnt != SAT) begin
            run_cnt <= run_cnt + CW'(1);
        end
    end

    assign qual_o  = lvl_i && (run_cnt == LAST);
    assign spike_o = !lvl_i && (run_cnt != '0) && (run_cnt < SAT);
endmodule

// File: rtl/th_timer.sv
// Message window timer: counts cycles while enabled, clears otherwise.
// expire_o is high in the LIMIT-th enabled cycle.
// Assumes: LIMIT >= 2.
module th_timer #(
    parameter int LIMIT = 625
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic expire_o
);
    localparam int TW = $clog2(LIMIT);
    localparam logic [TW-1:0] END_VAL = TW'(LIMIT - 1);

    logic [TW-1:0] cnt;

    // Advance while waiting for the message, hold at the end value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en_i) begin
            cnt <= '0;
        end else if (cnt != END_VAL) begin
            cnt <= cnt + TW'(1);
        end
    end

    assign expire_o = en_i && (cnt == END_VAL);
endmodule

// File: rtl/timing_trigger_handler.sv
// Endpoint trigger handler: pairs a qualified timing pulse with the later
// trigger message, strobes valid/invalid, flags spikes, extra pulses and
// late messages, and waits for the user release after every trigger.
// Assumes: msg_strobe_i and release_i are synchronous one-or-more-cycle
// strobes; trg_raw_i is fully asynchronous.
module timing_trigger_handler
    import th_pkg::*;
#(
    parameter int SYNC_STAGES     = 2,
    parameter int MIN_PULSE_CYC   = 5,
    parameter int MSG_TIMEOUT_CYC = 625
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trg_raw_i,
    input  logic              trg_invert_i,
    input  logic              msg_strobe_i,
    input  logic              release_i,
    output logic              valid_o,
    output logic              invalid_o,
    output logic              busy_o,
    output logic              multi_o,
    output logic              spike_o,
    output logic              timeout_o,
    output logic [STAT_W-1:0] status_o
);
    logic      trg_lvl;
    logic      pulse_ok;
    logic      pulse_short;
    logic      win_expire;
    th_state_e state, state_nx;

    logic valid_q, invalid_q, miss_q, multi_q, late_q, spike_q;
    logic valid_nx, invalid_nx, clr_flags, miss_set, multi_set, late_set;

    th_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_i    (trg_raw_i),
        .invert_i (trg_invert_i),
        .lvl_o    (trg_lvl)
    );

    th_width #(.MIN_CYC(MIN_PULSE_CYC)) u_width (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   (trg_lvl),
        .qual_o  (pulse_ok),
        .spike_o (pulse_short)
    );

    th_timer #(.LIMIT(MSG_TIMEOUT_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (state == ST_WAIT_MSG),
        .expire_o (win_expire)
    );

    // Next-state and event decode; release outranks pulses in the same cycle.
    always_comb begin
        state_nx   = state;
        valid_nx   = 1'b0;
        invalid_nx = 1'b0;
        clr_flags  = 1'b0;
        miss_set   = 1'b0;
        multi_set  = 1'b0;
        late_set   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (pulse_ok) begin
                    valid_nx = 1'b1;
                    state_nx = msg_strobe_i ? ST_WAIT_REL : ST_WAIT_MSG;
                end else if (msg_strobe_i) begin
                    invalid_nx = 1'b1;
                    miss_set   = 1'b1;
                    state_nx   = ST_WAIT_REL;
                end
            end
            ST_WAIT_MSG: begin
                multi_set = pulse_ok;
                if (msg_strobe_i) begin
                    state_nx = ST_WAIT_REL;
                end else if (win_expire) begin
                    late_set = 1'b1;
                    state_nx = ST_TIMEOUT;
                end
            end
            ST_TIMEOUT: begin
                if (release_i) begin
                    clr_flags = 1'b1;
                    state_nx  = ST_IDLE;
                end else begin
                    multi_set = pulse_ok;
                    if (msg_strobe_i) begin
                        state_nx = ST_WAIT_REL;
                    end
                end
            end
            ST_WAIT_REL: begin
                if (release_i) begin
                    clr_flags = 1'b1;
                    state_nx  = ST_IDLE;
                end else begin
                    multi_set = pulse_ok;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State, strobes and sticky flags (a new event outranks a clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            valid_q   <= 1'b0;
            invalid_q <= 1'b0;
            miss_q    <= 1'b0;
            multi_q   <= 1'b0;
            late_q    <= 1'b0;
            spike_q   <= 1'b0;
        end else begin
            state     <= state_nx;
            valid_q   <= valid_nx;
            invalid_q <= invalid_nx;
            miss_q    <= (miss_q  & ~clr_flags) | miss_set;
            multi_q   <= (multi_q & ~clr_flags) | multi_set;
            late_q    <= (late_q  & ~clr_flags) | late_set;
            spike_q   <= (spike_q & ~clr_flags) | pulse_short;
        end
    end

    assign valid_o   = valid_q;
    assign invalid_o = invalid_q;
    assign busy_o    = (state != ST_IDLE);
    assign multi_o   = multi_q;
    assign spike_o   = spike_q;
    assign timeout_o = late_q;

    // Pack the status word for the trigger channel.
    always_comb begin
        status_o               = '0;
        status_o[STAT_MISSING] = miss_q;
        status_o[STAT_MULTI]   = multi_q;
        status_o[STAT_LATE]    = late_q;
        status_o[STAT_SPIKE]   = spike_q;
    end
endmodule

// File: rtl/th_checker.sv
// Protocol checker for timing_trigger_handler, attached by bind.
// Assumes: observes top-level ports only.
module th_checker (
    input logic clk,
    input logic rst_n,
    input logic release_i,
    input logic valid_o,
    input logic invalid_o,
    input logic busy_o,
    input logic multi_o,
    input logic timeout_o
);
    assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_invalid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |=> !invalid_o);

    assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && invalid_o));

    assert_strobe_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o || invalid_o) |-> busy_o);

    assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !release_i) |=> busy_o);

    assert_multi_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        multi_o |-> busy_o);

    assert_timeout_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_o && !release_i) |=> timeout_o);

    assert_release_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_o && release_i) |=> (!timeout_o && !multi_o && !busy_o));
endmodule

bind timing_trigger_handler th_checker u_th_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .release_i (release_i),
    .valid_o   (valid_o),
    .invalid_o (invalid_o),
    .busy_o    (busy_o),
    .multi_o   (multi_o),
    .timeout_o (timeout_o)
);

// File: tb/tb_timing_trigger_handler.sv
module tb_timing_trigger_handler;
    localparam int SP = 5;
    localparam int TO = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trg = 1'b0, inv = 1'b0, msg = 1'b0, rel = 1'b0;
    logic valid_o, invalid_o, busy_o, multi_o, spike_o, timeout_o;
    logic [3:0] status_o;

    int n_chk = 0, n_fail = 0, n_valid = 0, n_invalid = 0;
    bit done = 0;

    always #4 clk = ~clk;

    timing_trigger_handler #(.SYNC_STAGES(2), .MIN_PULSE_CYC(SP), .MSG_TIMEOUT_CYC(TO)) dut (
        .clk(clk), .rst_n(rst_n), .trg_raw_i(trg), .trg_invert_i(inv),
        .msg_strobe_i(msg), .release_i(rel), .valid_o(valid_o), .invalid_o(invalid_o),
        .busy_o(busy_o), .multi_o(multi_o), .spike_o(spike_o), .timeout_o(timeout_o),
        .status_o(status_o)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: wire delay queue, active-run length, trigger phase.
    int  mq[$] = '{0, 0};
    int  m_run = 0, m_phase = 0, m_wait = 0;
    bit  e_valid, e_invalid, e_miss, e_multi, e_late, e_spike;
    bit  m_lvl, m_qual, m_short, m_clr;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq = '{0, 0}; m_run = 0; m_phase = 0; m_wait = 0;
            e_valid = 0; e_invalid = 0; e_miss = 0; e_multi = 0; e_late = 0; e_spike = 0;
        end else begin
            m_lvl   = (mq[0] != 0);
            m_qual  = m_lvl && (m_run == SP - 1);
            m_short = !m_lvl && (m_run > 0) && (m_run < SP);
            m_run   = m_lvl ? ((m_run < SP) ? m_run + 1 : SP) : 0;
            void'(mq.pop_front());
            mq.push_back(int'(trg ^ inv));
            e_valid = 0; e_invalid = 0; m_clr = 0;
            case (m_phase)
                0: if (m_qual) begin
                       e_valid = 1; m_wait = 0; m_phase = msg ? 3 : 1;
                   end else if (msg) begin
                       e_invalid = 1; e_miss = 1; m_phase = 3;
                   end
                1: begin
                       if (m_qual) e_multi = 1;
                       if (msg) m_phase = 3;
                       else if (m_wait == TO - 1) begin e_late = 1; m_phase = 2; end
                       else m_wait++;
                   end
                2: if (rel) begin m_clr = 1; m_phase = 0; end
                   else begin
                       if (m_qual) e_multi = 1;
                       if (msg) m_phase = 3;
                   end
                default: if (rel) begin m_clr = 1; m_phase = 0; end
                         else if (m_qual) e_multi = 1;
            endcase
            if (m_clr) begin e_miss = 0; e_multi = 0; e_late = 0; e_spike = 0; end
            if (m_short) e_spike = 1;
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2", "valid_o", int'(valid_o), int'(e_valid));
            chk("R5", "invalid_o", int'(invalid_o), int'(e_invalid));
            chk("R10", "busy_o", int'(busy_o), int'(m_phase != 0));
            chk("R4", "multi_o", int'(multi_o), int'(e_multi));
            chk("R3", "spike_o", int'(spike_o), int'(e_spike));
            chk("R7", "timeout_o", int'(timeout_o), int'(e_late));
            chk("R9", "status_o", int'(status_o), int'({e_spike, e_late, e_multi, e_miss}));
        end
    end

    // Strobe counters sampled at the edge (values settled from the previous edge).
    always @(posedge clk) begin
        if (rst_n) begin
            if (valid_o) n_valid++;
            if (invalid_o) n_invalid++;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(int n);
        trg = inv ? 1'b0 : 1'b1;
        tick(n);
        trg = inv ? 1'b1 : 1'b0;
    endtask

    task automatic send_msg();
        msg = 1'b1; tick(1); msg = 1'b0;
    endtask

    task automatic do_rel();
        rel = 1'b1; tick(1); rel = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog run did not complete");
        finish_run();
    end

    initial begin
        int v0, i0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1", "valid_o", int'(valid_o), 0);
        chk("R1", "busy_o", int'(busy_o), 0);
        chk("R1", "status_o", int'(status_o), 0);
        chk("R1", "flags", int'({multi_o, spike_o, timeout_o, invalid_o}), 0);

        // R2 latency, R6 release ignored while waiting for message
        trg = 1'b1; tick(SP + 2);
        chk("R2", "valid_o at latency", int'(valid_o), 1);
        tick(1);
        chk("R2", "valid_o single", int'(valid_o), 0);
        chk("R10", "busy_o after valid", int'(busy_o), 1);
        trg = 1'b0;
        do_rel(); tick(1);
        chk("R6", "busy_o after early release", int'(busy_o), 1);
        send_msg(); tick(2);
        chk("R6", "busy_o before release", int'(busy_o), 1);
        do_rel();
        chk("R10", "busy_o after release", int'(busy_o), 0);
        tick(2);
        chk("R2", "valid count", n_valid, 1);

        // R3 spike, R6 release ignored in idle
        v0 = n_valid;
        pulse(SP - 2); tick(6);
        chk("R3", "spike_o", int'(spike_o), 1);
        chk("R3", "status spike bit", int'(status_o[3]), 1);
        chk("R3", "no valid on spike", n_valid, v0);
        chk("R3", "no busy on spike", int'(busy_o), 0);
        do_rel(); tick(1);
        chk("R6", "spike held over idle release", int'(spike_o), 1);

        // R5 message without pulse, R4 pulse while waiting release, R6 message ignored
        i0 = n_invalid;
        send_msg();
        chk("R5", "invalid_o", int'(invalid_o), 1);
        chk("R5", "status missing bit", int'(status_o[0]), 1);
        tick(1);
        chk("R5", "invalid single", int'(invalid_o), 0);
        pulse(8); tick(4);
        chk("R4", "multi_o after pulse in wait", int'(multi_o), 1);
        chk("R4", "no valid while busy", n_valid, v0);
        send_msg(); tick(2);
        chk("R6", "message ignored in wait release", n_invalid, i0 + 1);
        do_rel(); tick(1);
        chk("R9", "status cleared", int'(status_o), 0);
        chk("R9", "multi cleared", int'(multi_o), 0);
        chk("R9", "spike cleared", int'(spike_o), 0);

        // R4 multiple pulses before message
        v0 = n_valid;
        pulse(8); tick(3); pulse(8); tick(4);
        chk("R4", "multi_o", int'(multi_o), 1);
        chk("R4", "status multi bit", int'(status_o[1]), 1);
        send_msg(); tick(2);
        chk("R4", "multi held", int'(multi_o), 1);
        chk("R4", "one valid only", n_valid, v0 + 1);
        do_rel(); tick(1);
        chk("R9", "multi cleared", int'(multi_o), 0);

        // R7 timeout window and late message
        pulse(8); tick(TO - 2);
        chk("R7", "timeout_o before window end", int'(timeout_o), 0);
        tick(1);
        chk("R7", "timeout_o at window end", int'(timeout_o), 1);
        chk("R7", "status late bit", int'(status_o[2]), 1);
        send_msg(); tick(1);
        chk("R7", "busy after late message", int'(busy_o), 1);
        chk("R7", "timeout held", int'(timeout_o), 1);
        do_rel(); tick(1);
        chk("R9", "timeout cleared", int'(timeout_o), 0);

        // R9 release directly from timeout
        pulse(8); tick(TO + 2);
        chk("R7", "timeout_o", int'(timeout_o), 1);
        do_rel();
        chk("R9", "timeout cleared by release", int'(timeout_o), 0);
        chk("R9", "busy cleared by release", int'(busy_o), 0);

        // R11 pulse qualifies together with message
        v0 = n_valid; i0 = n_invalid;
        trg = 1'b1; tick(SP + 1);
        msg = 1'b1; tick(1); msg = 1'b0;
        tick(1); trg = 1'b0;
        tick(TO + 5);
        chk("R11", "valid once", n_valid, v0 + 1);
        chk("R11", "no invalid", n_invalid, i0);
        chk("R11", "no timeout", int'(timeout_o), 0);
        chk("R11", "busy waiting release", int'(busy_o), 1);
        do_rel(); tick(1);

        // R9 release beats a pulse qualifying in the same cycle
        send_msg(); tick(1);
        v0 = n_valid;
        trg = 1'b1; tick(SP + 1);
        rel = 1'b1; tick(1); rel = 1'b0;
        tick(3); trg = 1'b0; tick(4);
        chk("R9", "multi not set", int'(multi_o), 0);
        chk("R9", "idle after release", int'(busy_o), 0);
        chk("R9", "pulse dropped", n_valid, v0);
        chk("R9", "no spike from long pulse", int'(spike_o), 0);

        // R8 inverted polarity
        inv = 1'b1; trg = 1'b1; tick(4);
        v0 = n_valid;
        pulse(8); tick(2);
        chk("R8", "valid with active-low wire", n_valid, v0 + 1);
        send_msg(); do_rel(); tick(1);
        pulse(2); tick(6);
        chk("R8", "spike with active-low wire", int'(spike_o), 1);
        chk("R8", "no valid on inverted spike", n_valid, v0 + 1);
        inv = 1'b0; trg = 1'b0; tick(4);

        // R2 long pulse gives a single strobe
        v0 = n_valid;
        pulse(30); tick(2);
        chk("R2", "long pulse single valid", n_valid, v0 + 1);
        send_msg(); do_rel(); tick(5);
        chk("R9", "status clear at end", int'(status_o), 0);

        finish_run();
    end
endmodule